// File: doc/BRIEF.md
# Multi-channel tamper event controller

This block turns tamper detections on five channels into a sticky per-channel source record, one shared interrupt flag and a timestamp register. Each channel carries a two-bit action setting. In wake and capture modes the channel reacts to an edge pulse that the input conditioning stage has already qualified for polarity and debounce. In active-layer mode the channel ignores that pulse. It instead compares the value returned on its loop input with the pattern bit the block drove on its shield output one cycle earlier. The pattern comes from a small LFSR.

A free-running counter value comes in from outside, and a capturing event copies it into the timestamp register. An external tamper event input can also raise a tamper condition when its enable is high. It records its own source bit above the channel bits. Software clears source bits with a write-one mask and clears the interrupt flag with a separate pulse. After detection is enabled, the channels are held off for a guard window. This keeps the settling of the conditioning stage from raising a false interrupt.

Top module: `tamper_event_ctrl`

## Requirements
- R1: After reset, id_q is 0, tamper_irq is 0 and stamp is 0.
- R2: A channel whose ch_mode field (bits 2i+1:2i) is 00 (off) never sets its source bit, the flag or the timestamp, whatever its edge or loop input does.
- R3: In mode 01 (wake), an edge pulse sampled at an armed clock edge sets source bit i and tamper_irq at that edge, and stamp keeps its value.
- R4: In mode 10 (capture), an edge pulse sampled at an armed clock edge sets source bit i and tamper_irq, and loads stamp with the cnt_val sampled at that edge.
- R5: In mode 11 (active-layer), the channel ignores its edge pulse. If ch_loop_in[i] differs from the shield_out value of the previous cycle at an armed edge, the channel sets source bit i and tamper_irq and loads stamp with cnt_val. A matching loopback raises nothing.
- R6: A channel event counts only when detect_en is high and detect_en has already been sampled high on GUARD_CYC (10) earlier edges since it last was low. Events at the first 10 such edges, or while detect_en is low, have no effect.
- R7: Source bits stay set until id_clr writes a one to that bit position. If a new event lands in the same cycle as the clear, the event wins.
- R8: ext_evt sets source bit NUM_CH (bit 5) and tamper_irq and loads stamp, but only while ext_evt_en is high. The guard window and detect_en do not affect it.
- R9: When several channels fire at the same edge, all their source bits are set together and a single stamp value (that edge's cnt_val) is loaded.
- R10: tamper_irq stays high until an irq_clr pulse. A tamper event in the same cycle as irq_clr keeps the flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| detect_en | input | 1 | Tamper detection enable; its rise starts the guard window |
| ch_mode | input | 10 | Two-bit action per channel: 00 off, 01 wake, 10 capture, 11 active-layer |
| ch_edge | input | 5 | Qualified edge pulse per channel |
| ch_loop_in | input | 5 | Returned active-layer value per channel |
| cnt_val | input | 32 | Current counter value for timestamps |
| ext_evt | input | 1 | External tamper event pulse |
| ext_evt_en | input | 1 | Enable for the external event |
| id_clr | input | 6 | Write-one-to-clear mask for the source bits |
| irq_clr | input | 1 | Clear pulse for the interrupt flag |
| shield_out | output | 1 | Driven active-layer pattern bit |
| id_q | output | 6 | Sticky source bits: channels 0 to 4, external event at bit 5 |
| tamper_irq | output | 1 | Shared tamper interrupt flag |
| stamp | output | 32 | Captured counter value |

## Verification
A wrong guard count shows up at the ports within the eleventh edge after enabling. There, an edge that should be accepted is dropped, or one that should be dropped lands in id_q. A bad delay register for the active-layer reference shows up on the next cycle. It raises spurious source bits on a channel whose loopback is correct. A mis-decoded action setting shows up one edge after the event, as a stamp that moves on a wake event or stays put on a capture event. The scoreboard compares id_q, tamper_irq and stamp after every edge, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_WAKE   = 2'b01,
        ACT_STAMP  = 2'b10,
        ACT_SHIELD = 2'b11
    } act_e;
endpackage

// File: rtl/tamper_guard.sv
module tamper_guard #(
    parameter int GUARD_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic detect_en,
    output logic armed
);
    localparam int CW = $clog2(GUARD_CYC + 1);
    localparam logic [CW-1:0] START = CW'(GUARD_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!detect_en) begin
            g_d.cnt = START;
        end else if (g_q.cnt != '0) begin
            g_d.cnt = g_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{cnt: START};
        else        g_q <= g_d;
    end

    assign armed = detect_en && (g_q.cnt == '0);

    // R6: the window counter never leaves its range
    assert_guard_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.cnt <= START);

    // R6: dropping the enable always restarts the full window
    assert_guard_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !detect_en |=> (g_q.cnt == START));
endmodule

// File: rtl/tamper_lfsr.sv
module tamper_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input  logic clk,
    input  logic rst_n,
    output logic shield_out,
    output logic ref_bit
);
    typedef struct packed {
        logic [W-1:0] lfsr;
        logic         ref_b;
    } pat_t;

    pat_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.lfsr  = {1'b0, p_q.lfsr[W-1:1]} ^ (p_q.lfsr[0] ? TAPS : '0);
        p_d.ref_b = p_q.lfsr[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{lfsr: SEED, ref_b: 1'b0};
        else        p_q <= p_d;
    end

    assign shield_out = p_q.lfsr[0];
    assign ref_bit    = p_q.ref_b;

    // R5: the pattern generator must never lock up at zero
    assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.lfsr != '0);
endmodule

// File: rtl/tamper_chan.sv
module tamper_chan
    import tamper_pkg::*;
(
    input  act_e mode,
    input  logic armed,
    input  logic edge_in,
    input  logic loop_in,
    input  logic ref_bit,
    output logic hit,
    output logic want_stamp
);
    always_comb begin
        hit        = 1'b0;
        want_stamp = 1'b0;
        if (armed) begin
            unique case (mode)
                ACT_OFF:    hit = 1'b0;
                ACT_WAKE:   hit = edge_in;
                ACT_STAMP:  begin hit = edge_in;            want_stamp = edge_in;            end
                ACT_SHIELD: begin hit = loop_in ^ ref_bit;  want_stamp = loop_in ^ ref_bit;  end
                default:    hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tamper_event_ctrl.sv
module tamper_event_ctrl
    import tamper_pkg::*;
#(
    parameter int NUM_CH    = 5,
    parameter int TS_W      = 32,
    parameter int GUARD_CYC = 10,
    parameter int LFSR_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  detect_en,
    input  logic [2*NUM_CH-1:0]   ch_mode,
    input  logic [NUM_CH-1:0]     ch_edge,
    input  logic [NUM_CH-1:0]     ch_loop_in,
    input  logic [TS_W-1:0]       cnt_val,
    input  logic                  ext_evt,
    input  logic                  ext_evt_en,
    input  logic [NUM_CH:0]       id_clr,
    input  logic                  irq_clr,
    output logic                  shield_out,
    output logic [NUM_CH:0]       id_q,
    output logic                  tamper_irq,
    output logic [TS_W-1:0]       stamp
);
    localparam int ID_W = NUM_CH + 1;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            irq;
        logic [TS_W-1:0] ts;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              armed;
    logic              ref_bit;
    logic [NUM_CH-1:0] chan_hit;
    logic [NUM_CH-1:0] chan_cap;
    logic              ext_fire;

    tamper_guard #(.GUARD_CYC(GUARD_CYC)) guard_i (
        .clk(clk), .rst_n(rst_n), .detect_en(detect_en), .armed(armed)
    );

    tamper_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(8'hB8)), .SEED(LFSR_W'(1))) lfsr_i (
        .clk(clk), .rst_n(rst_n), .shield_out(shield_out), .ref_bit(ref_bit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        tamper_chan chan_i (
            .mode       (act_e'(ch_mode[2*i +: 2])),
            .armed      (armed),
            .edge_in    (ch_edge[i]),
            .loop_in    (ch_loop_in[i]),
            .ref_bit    (ref_bit),
            .hit        (chan_hit[i]),
            .want_stamp (chan_cap[i])
        );
    end

    assign ext_fire = ext_evt && ext_evt_en;

    always_comb begin
        s_d     = s_q;
        s_d.id  = (s_q.id & ~id_clr) | {ext_fire, chan_hit};
        s_d.irq = (s_q.irq && !irq_clr) || ext_fire || (chan_hit != '0);
        if (ext_fire || (chan_cap != '0)) begin
            s_d.ts = cnt_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign id_q       = s_q.id;
    assign tamper_irq = s_q.irq;
    assign stamp      = s_q.ts;

    // R6: no channel may report while the guard window is open
    assert_guard_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (chan_hit == '0));

    // R3: without a capturing event the timestamp holds
    assert_stamp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_fire && (chan_cap == '0)) |=> $stable(stamp));

    // R7: no source bit falls without a clear
    assert_id_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_clr == '0) |=> ((id_q & $past(id_q)) == $past(id_q)));

    // R10: the flag holds until cleared
    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_irq && !irq_clr) |=> tamper_irq);

    // R8: a disabled external event cannot set its source bit
    assert_ext_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_evt_en && !id_q[NUM_CH]) |=> !id_q[NUM_CH]);

    // R9: every firing channel is recorded and the flag rises
    assert_multi_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_hit != '0) |=> (tamper_irq &&
            ((id_q[NUM_CH-1:0] & $past(chan_hit)) == $past(chan_hit))));
endmodule

// File: tb/tamper_event_ctrl_tb_top.sv
module tamper_event_ctrl_tb_top;
    localparam int N = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          detect_en = 1'b0;
    logic [2*N-1:0] ch_mode = '0;
    logic [N-1:0]  ch_edge = '0;
    logic [N-1:0]  inv_mask = '0;
    logic [N-1:0]  ch_loop_in;
    logic [31:0]   cnt_val = '0;
    logic          ext_evt = 1'b0;
    logic          ext_evt_en = 1'b0;
    logic [N:0]    id_clr = '0;
    logic          irq_clr = 1'b0;
    logic          shield_out;
    logic [N:0]    id_q;
    logic          tamper_irq;
    logic [31:0]   stamp;

    logic          loop_reg;

    always #10 clk = ~clk;  // 50 MHz

    tamper_event_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .detect_en(detect_en), .ch_mode(ch_mode),
        .ch_edge(ch_edge), .ch_loop_in(ch_loop_in), .cnt_val(cnt_val),
        .ext_evt(ext_evt), .ext_evt_en(ext_evt_en), .id_clr(id_clr),
        .irq_clr(irq_clr), .shield_out(shield_out), .id_q(id_q),
        .tamper_irq(tamper_irq), .stamp(stamp)
    );

    // one-cycle external loop for the active-layer channels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loop_reg <= 1'b0;
        else        loop_reg <= shield_out;
    end
    assign ch_loop_in = {N{loop_reg}} ^ inv_mask;

    typedef struct {
        int          cyc;
        logic [N:0]  id;
        logic        irq;
        logic [31:0] ts;
        string       tag;
    } item_t;

    item_t sb[$];
    int    cyc_cnt = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // reference model state
    logic [N:0]  m_id = '0;
    logic        m_irq = 1'b0;
    logic [31:0] m_ts = '0;
    int          m_guard = 10;
    logic        m_de = 1'b0;
    logic [1:0]  m_mode [N];

    always @(posedge clk) if (rst_n) cyc_cnt <= cyc_cnt + 1;

    // monitor: pops items due at this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc == cyc_cnt) begin
            item_t it;
            it = sb.pop_front();
            n_checks++;
            if (id_q !== it.id || tamper_irq !== it.irq || stamp !== it.ts) begin
                n_fail++;
                $display("FAIL %s: id=%h irq=%b stamp=%h expected id=%h irq=%b stamp=%h",
                         it.tag, id_q, tamper_irq, stamp, it.id, it.irq, it.ts);
            end
        end
    end

    task automatic set_mode(input int ch, input logic [1:0] m);
        m_mode[ch] = m;
    endtask

    // driver: applies one cycle of stimulus and pushes the expectation
    task automatic step(input logic [N-1:0] e, input logic [N-1:0] inv,
                        input logic ex, input logic exen,
                        input logic [N:0] clr, input logic iclr, input string tag);
        logic        armed;
        logic [N-1:0] hit;
        logic        cap;
        logic        xf;
        item_t       it;
        @(negedge clk);
        for (int i = 0; i < N; i++) ch_mode[2*i +: 2] = m_mode[i];
        detect_en  = m_de;
        ch_edge    = e;
        inv_mask   = inv;
        ext_evt    = ex;
        ext_evt_en = exen;
        id_clr     = clr;
        irq_clr    = iclr;
        cnt_val    = 32'hA500_0000 + 32'(cyc_cnt * 7);
        armed = m_de && (m_guard == 0);
        hit = '0;
        cap = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (armed) begin
                case (m_mode[i])
                    2'b01: hit[i] = e[i];
                    2'b10: begin hit[i] = e[i]; cap = cap | e[i]; end
                    2'b11: begin hit[i] = inv[i]; cap = cap | inv[i]; end
                    default: hit[i] = 1'b0;
                endcase
            end
        end
        xf = ex && exen;
        m_id  = (m_id & ~clr) | {xf, hit};
        m_irq = (m_irq && !iclr) || xf || (hit != '0);
        if (xf || cap) m_ts = cnt_val;
        if (!m_de) m_guard = 10;
        else if (m_guard != 0) m_guard = m_guard - 1;
        it.cyc = cyc_cnt + 1;
        it.id  = m_id;
        it.irq = m_irq;
        it.ts  = m_ts;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step('0, '0, 1'b0, 1'b0, '0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_mode[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        n_checks++;
        if (id_q !== '0 || tamper_irq !== 1'b0 || stamp !== '0) begin
            n_fail++;
            $display("FAIL R1: id=%h irq=%b stamp=%h expected id=0 irq=0 stamp=0",
                     id_q, tamper_irq, stamp);
        end
        set_mode(0, 2'b00); set_mode(1, 2'b01); set_mode(2, 2'b10);
        set_mode(3, 2'b11); set_mode(4, 2'b10);
        // R6: disabled detection ignores everything on the channels
        step(5'h1F, 5'h1F, 1'b0, 1'b0, '0, 1'b0, "R6 disabled");
        idle(2, "R6 disabled idle");
        // R6: guard window after enabling
        m_de = 1'b1;
        for (int k = 0; k < 10; k++) step(5'h1F, 5'h08, 1'b0, 1'b0, '0, 1'b0, "R6 guard");
        step(5'h02, '0, 1'b0, 1'b0, '0, 1'b0, "R6 R3 first armed wake");
        step('0, '0, 1'b0, 1'b0, 6'h3F, 1'b1, "R7 clear all");
        // R2: off channel
        step(5'h01, 5'h01, 1'b0, 1'b0, '0, 1'b0, "R2 off channel");
        idle(1, "R2 off idle");
        // R3: wake keeps stamp
        step(5'h04, '0, 1'b0, 1'b0, '0, 1'b0, "R4 capture");
        step(5'h02, '0, 1'b0, 1'b0, '0, 1'b0, "R3 wake keeps stamp");
        step('0, '0, 1'b0, 1'b0, 6'h02, 1'b0, "R7 partial clear");
        step('0, '0, 1'b0, 1'b0, '0, 1'b0, "R7 sticky");
        step('0, '0, 1'b0, 1'b0, 6'h3F, 1'b1, "R7 R10 clear");
        // R5: active layer
        step(5'h08, '0, 1'b0, 1'b0, '0, 1'b0, "R5 edge ignored");
        idle(3, "R5 matching loop");
        step('0, 5'h08, 1'b0, 1'b0, '0, 1'b0, "R5 mismatch");
        step('0, '0, 1'b0, 1'b0, 6'h3F, 1'b1, "R5 clear");
        // R8: external event
        step('0, '0, 1'b1, 1'b0, '0, 1'b0, "R8 disabled ext");
        step('0, '0, 1'b1, 1'b1, '0, 1'b0, "R8 enabled ext");
        step('0, '0, 1'b0, 1'b0, 6'h3F, 1'b1, "R8 clear");
        // R9: simultaneous channels
        step(5'h16, 5'h08, 1'b0, 1'b0, '0, 1'b0, "R9 simultaneous");
        // R7: clear and set same cycle
        step(5'h02, '0, 1'b0, 1'b0, 6'h02, 1'b0, "R7 set wins");
        // R10
        step('0, '0, 1'b0, 1'b0, '0, 1'b1, "R10 irq clear");
        step(5'h02, '0, 1'b0, 1'b0, '0, 1'b1, "R10 set wins");
        step('0, '0, 1'b0, 1'b0, 6'h3F, 1'b1, "R10 clear");
        // R8: external event during guard and while disabled
        m_de = 1'b0;
        step('0, '0, 1'b1, 1'b1, '0, 1'b0, "R8 ext while disabled");
        m_de = 1'b1;
        step(5'h04, '0, 1'b1, 1'b1, '0, 1'b0, "R8 R6 ext in guard");
        // mixed traffic
        for (int k = 0; k < 300; k++) begin
            logic [N-1:0] e;
            logic [N-1:0] v;
            e = 5'($urandom) & 5'($urandom);
            v = 5'($urandom) & 5'($urandom) & 5'($urandom);
            if (k % 40 == 7) begin
                m_de = 1'b0;
            end else if (k % 40 == 9) begin
                m_de = 1'b1;
            end
            if (k % 50 == 20) set_mode(k % N, 2'($urandom));
            step(e, v, ($urandom % 8) == 0, ($urandom % 2) == 0,
                 (($urandom % 4) == 0) ? 6'($urandom) : 6'h00,
                 ($urandom % 5) == 0, "R3 R4 R5 R9 mixed");
        end
        idle(3, "R7 final idle");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule